// File: doc/BRIEF.md
# Fractional Nanosecond Baud Tick Generator

This block produces the oversampling strobe that paces a UART receiver and transmitter, together with a slower strobe that marks each bit. Software does not program a cycle count. It programs the length of one sample period in nanoseconds: a 24-bit whole-nanosecond part and an 8-bit fraction counted in 1/255 ns steps. The block runs from a fixed reference clock whose period, in whole nanoseconds, is a build parameter. A phase accumulator advances by that period on every clock and issues a sample strobe once the programmed time has elapsed. It keeps the overshoot for the next period, so the average strobe rate is exact even when the period is not a multiple of the clock period.

The fraction is handled by a second accumulator. Each sample period adds the fraction value to it, and whenever that sum reaches 255 the period is made one nanosecond longer. Over 255 periods the extra time therefore totals the fraction in nanoseconds. A mode word chooses 8 or 16 samples per bit, and the bit strobe fires with every 8th or 16th sample strobe. Software normally takes 8 samples per bit at line rates of 4 Mbit/s and faster, and 16 below that. For a rate B with S samples per bit, the whole part is floor(1e9/(B*S)) and the fraction is the leftover nanoseconds scaled by 255/(S*B).

Both inputs are plain register-write strobes with their data, and both outputs are single-cycle pulses. There is no stream handshake.

Top module: `ns_baud_tick_gen`

## Requirements
- R1: After reset both strobes are low, the programmed period is zero so no strobe fires, and the mode is 16 samples per bit.
- R2: A divisor write (`div_wr` high at a clock edge) takes bits 31:8 of `div_wdata` as the whole-nanosecond sample period I and bits 7:0 as the fraction F in units of 1/255 ns.
- R3: Count clock edges from the edge that captured the divisor write, with that edge as number 0, and let the reference period be P ns (default 5). Sample strobe n (n = 1, 2, ...) is then registered at the first edge k with k*P >= n*I + floor(n*F/255). `sample_tick` is high during the cycle that follows that edge. I must be 0 or at least P.
- R4: The fraction lengthens sample periods by exactly 1 ns at the points where floor(n*F/255) increases, so F = 255 makes every period I+1 ns long and F = 0 never lengthens one.
- R5: While the programmed whole part I is zero, no sample strobe or bit strobe fires, whatever the fraction.
- R6: A mode write (`mode_wr` high) with data 32'h26731000 selects 8 samples per bit. Data 32'h6EF71000 selects 16 samples per bit.
- R7: `bit_tick` is high only together with `sample_tick`. It marks every 8th or 16th sample strobe, counted from the most recent restart.
- R8: A mode write whose data is neither code changes neither the mode nor the bit count.
- R9: A divisor write restarts the phase accumulator, the fraction accumulator and the bit count. No strobe is registered at the writing edge.
- R10: A mode write with a valid code restarts the bit count but not the sample timing. The bit strobe then falls on the 8th or 16th sample strobe after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, period REF_PERIOD_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 32 | Divisor data: whole ns in 31:8, fraction in 7:0 |
| mode_wr | input | 1 | Oversampling-mode write strobe |
| mode_wdata | input | 32 | Mode code word |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit strobe, coincident with a sample strobe |

## Verification
The assertions assume that every divisor write programs a whole part that is zero or no shorter than the reference period. Under that assumption at most one sample strobe is due per clock, and the phase accumulator never holds more than one period of time. The random stimulus draws whole parts from the reference period up to 80 ns and fractions over the full 0 to 255 range. The halt case uses a zero whole part, and no write ever programs a whole part between zero and the reference period. Mode writes in the random cases always go in before the divisor restart. The one mid-stream mode write is placed in a cycle where no sample strobe can fall, so the bit count has a single defined starting point.

// File: rtl/ns_baud_pkg.sv
`timescale 1ns/1ps
package ns_baud_pkg;
  localparam logic [31:0] CODE_OSR_X8  = 32'h2673_1000;
  localparam logic [31:0] CODE_OSR_X16 = 32'h6EF7_1000;

  typedef enum logic {
    OSR_X16 = 1'b0,
    OSR_X8  = 1'b1
  } osr_e;
endpackage

// File: rtl/nsb_mode_reg.sv
`timescale 1ns/1ps
module nsb_mode_reg
  import ns_baud_pkg::*;
#(
  parameter int unsigned  REG_W   = 32,
  parameter logic [31:0]  CODE_LO = CODE_OSR_X8,
  parameter logic [31:0]  CODE_HI = CODE_OSR_X16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [REG_W-1:0] mode_wdata,
  output osr_e             osr_sel,
  output logic             mode_restart
);
  logic hit_lo, hit_hi;

  always_comb begin
    hit_lo       = (mode_wdata == REG_W'(CODE_LO));
    hit_hi       = (mode_wdata == REG_W'(CODE_HI));
    mode_restart = mode_wr && (hit_lo || hit_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            osr_sel <= OSR_X16;
    else if (mode_restart) osr_sel <= hit_lo ? OSR_X8 : OSR_X16;
  end

  // R8: unknown code words leave the mode untouched
  p_bad_code_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !hit_lo && !hit_hi) |=> $stable(osr_sel));
endmodule

// File: rtl/nsb_frac_carry.sv
`timescale 1ns/1ps
module nsb_frac_carry #(
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned FRAC_DEN = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              extend
);
  localparam int unsigned SUM_W = FRAC_W + 1;
  localparam logic [SUM_W-1:0] DEN = SUM_W'(FRAC_DEN);

  logic [FRAC_W-1:0] frac_q;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  wrapped;

  always_comb begin
    sum     = {1'b0, frac_q} + {1'b0, frac_in};
    extend  = (sum >= DEN);
    wrapped = extend ? (sum - DEN) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frac_q <= '0;
    else if (restart) frac_q <= '0;
    else if (step)    frac_q <= wrapped[FRAC_W-1:0];
  end

  // R4: residue always stays below the denominator
  p_frac_below_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, frac_q} < DEN));
  // R9: restart clears the residue
  p_frac_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (frac_q == '0));
endmodule

// File: rtl/nsb_phase_acc.sv
`timescale 1ns/1ps
module nsb_phase_acc #(
  parameter int unsigned INT_W  = 24,
  parameter int unsigned REF_NS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [INT_W-1:0] per_int,
  input  logic             extend,
  output logic             fire,
  output logic             tick_q
);
  localparam int unsigned ACC_W = INT_W + 2;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(REF_NS);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] target;
  logic             running;

  always_comb begin
    running = (per_int != '0);
    acc_sum = acc_q + STEP;
    target  = {2'b00, per_int} + {{(ACC_W-1){1'b0}}, extend};
    fire    = running && !restart && (acc_sum >= target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= fire;
      if (restart || !running) acc_q <= '0;
      else if (fire)           acc_q <= acc_sum - target;
      else                     acc_q <= acc_sum;
    end
  end

  // R3: carried time never exceeds one programmed period
  p_acc_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_int >= INT_W'(REF_NS)) |-> (acc_q <= {2'b00, per_int}));
  // R9: a restart empties the accumulator
  p_acc_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (acc_q == '0));
endmodule

// File: rtl/nsb_bit_div.sv
`timescale 1ns/1ps
module nsb_bit_div
  import ns_baud_pkg::*;
#(
  parameter int unsigned OSR_LO = 8,
  parameter int unsigned OSR_HI = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic fire,
  input  osr_e osr_sel,
  output logic bit_q
);
  localparam int unsigned CNT_W = $clog2(OSR_HI);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  logic             at_last;

  always_comb begin
    last_idx = (osr_sel == OSR_X8) ? CNT_W'(OSR_LO - 1) : CNT_W'(OSR_HI - 1);
    at_last  = (cnt_q == last_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (fire) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      bit_q <= at_last;
    end else begin
      bit_q <= 1'b0;
    end
  end

  // R7: sample count stays inside the selected ratio
  p_count_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= last_idx));
endmodule

// File: rtl/ns_baud_tick_gen.sv
`timescale 1ns/1ps
module ns_baud_tick_gen
  import ns_baud_pkg::*;
#(
  parameter int unsigned  REF_PERIOD_NS = 5,
  parameter int unsigned  REG_W         = 32,
  parameter int unsigned  FRAC_W        = 8,
  parameter int unsigned  FRAC_DEN      = 255,
  parameter int unsigned  OSR_LO        = 8,
  parameter int unsigned  OSR_HI        = 16,
  parameter logic [31:0]  MODE_CODE_LO  = CODE_OSR_X8,
  parameter logic [31:0]  MODE_CODE_HI  = CODE_OSR_X16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [REG_W-1:0] div_wdata,
  input  logic             mode_wr,
  input  logic [REG_W-1:0] mode_wdata,
  output logic             sample_tick,
  output logic             bit_tick
);
  localparam int unsigned INT_W = REG_W - FRAC_W;

  logic [REG_W-1:0]  div_q;
  logic [INT_W-1:0]  per_int;
  logic [FRAC_W-1:0] per_frac;
  osr_e              osr_sel;
  logic              mode_restart;
  logic              extend;
  logic              fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_wr) div_q <= div_wdata;
  end

  assign per_int  = div_q[REG_W-1:FRAC_W];
  assign per_frac = div_q[FRAC_W-1:0];

  nsb_mode_reg #(
    .REG_W(REG_W), .CODE_LO(MODE_CODE_LO), .CODE_HI(MODE_CODE_HI)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .osr_sel(osr_sel), .mode_restart(mode_restart)
  );

  nsb_frac_carry #(.FRAC_W(FRAC_W), .FRAC_DEN(FRAC_DEN)) u_frac (
    .clk(clk), .rst_n(rst_n), .restart(div_wr), .step(fire),
    .frac_in(per_frac), .extend(extend)
  );

  nsb_phase_acc #(.INT_W(INT_W), .REF_NS(REF_PERIOD_NS)) u_phase (
    .clk(clk), .rst_n(rst_n), .restart(div_wr), .per_int(per_int),
    .extend(extend), .fire(fire), .tick_q(sample_tick)
  );

  nsb_bit_div #(.OSR_LO(OSR_LO), .OSR_HI(OSR_HI)) u_bits (
    .clk(clk), .rst_n(rst_n), .restart(div_wr || mode_restart),
    .fire(fire), .osr_sel(osr_sel), .bit_q(bit_tick)
  );

  // R7: bit strobe only together with a sample strobe
  p_bit_with_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);
  // R9: the writing edge registers no strobe
  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (!sample_tick && !bit_tick));
  // R5: zero whole part halts the generator
  p_halt_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_int == '0) |=> !sample_tick);
  // R3: programmed whole part is zero or at least one reference period
  p_legal_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |-> ((div_wdata[REG_W-1:FRAC_W] == '0) ||
                (div_wdata[REG_W-1:FRAC_W] >= INT_W'(REF_PERIOD_NS))));
endmodule

// File: tb/ns_baud_tick_gen_tb.sv
`timescale 1ns/1ps
module ns_baud_tick_gen_tb;
  localparam int REF = 5;
  localparam logic [31:0] C8  = 32'h2673_1000;
  localparam logic [31:0] C16 = 32'h6EF7_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_wr = 1'b0;
  logic [31:0] div_wdata = '0;
  logic        mode_wr = 1'b0;
  logic [31:0] mode_wdata = '0;
  logic        sample_tick, bit_tick;

  int     checks = 0;
  int     failures = 0;
  bit     done = 1'b0;
  longint edge_cnt = 0;
  longint base = 0;

  ns_baud_tick_gen #(.REF_PERIOD_NS(REF)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  function automatic longint exp_edge(input int n, input int ii, input int ff);
    longint t;
    t = longint'(n) * ii + (longint'(n) * ff) / 255;
    return (t + REF - 1) / REF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic prog_div(input int ii, input int ff);
    @(negedge clk);
    div_wr = 1'b1;
    div_wdata = {ii[23:0], ff[7:0]};
    @(negedge clk);
    div_wr = 1'b0;
    base = edge_cnt;
  endtask

  task automatic set_mode(input logic [31:0] code);
    @(negedge clk);
    mode_wr = 1'b1;
    mode_wdata = code;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic collect(input int n_from, input int n_to, input int bit_ref,
                         input int osr, input int ii, input int ff, input string req);
    for (int n = n_from; n <= n_to; n++) begin
      int waited = 0;
      bit seen = 1'b0;
      bit exp_bit;
      while (!seen && waited < 2000) begin
        @(negedge clk);
        waited++;
        if (sample_tick) seen = 1'b1;
        else if (bit_tick) chk(1'b0, req, "bit without sample", 1, 0);
      end
      if (!seen) begin
        chk(1'b0, req, "sample tick missing", 0, n);
        return;
      end
      chk(edge_cnt - base == exp_edge(n, ii, ff), req, "tick edge",
          edge_cnt - base, exp_edge(n, ii, ff));
      exp_bit = (n > bit_ref) && (((n - bit_ref) % osr) == 0);
      chk(bit_tick == exp_bit, req, "bit tick", bit_tick, exp_bit);
    end
  endtask

  initial begin
    #(150000 * REF);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed_word;
    int quiet;
    seed_word = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, no strobes with a zero period
    quiet = 0;
    repeat (50) begin
      @(negedge clk);
      if (sample_tick || bit_tick) quiet++;
    end
    chk(quiet == 0, "R1", "strobes after reset", quiet, 0);

    // R1 R6: default mode is 16x; R2 R3 exact multiple
    prog_div(10, 0);
    collect(1, 34, 0, 16, 10, 0, "R1");

    // R3: period equal to the clock, strobe every cycle
    prog_div(5, 0);
    collect(1, 20, 0, 16, 5, 0, "R3");

    // R3: non-multiple period carried forward
    prog_div(7, 0);
    collect(1, 20, 0, 16, 7, 0, "R3");

    // R4: fraction at half and at full scale
    prog_div(12, 128);
    collect(1, 40, 0, 16, 12, 128, "R4");
    prog_div(5, 255);
    collect(1, 20, 0, 16, 5, 255, "R4");

    // R6: 8x code
    set_mode(C8);
    prog_div(9, 33);
    collect(1, 20, 0, 8, 9, 33, "R6");

    // R8: unknown code keeps 8x
    set_mode(32'h1234_5678);
    prog_div(10, 0);
    collect(1, 17, 0, 8, 10, 0, "R8");

    // R5: zero whole part halts even with a fraction
    prog_div(0, 77);
    quiet = 0;
    repeat (100) begin
      @(negedge clk);
      if (sample_tick || bit_tick) quiet++;
    end
    chk(quiet == 0, "R5", "strobes with zero period", quiet, 0);

    // R9: restart mid-stream realigns timing and bit count
    set_mode(C16);
    prog_div(15, 40);
    collect(1, 5, 0, 16, 15, 40, "R9");
    prog_div(15, 40);
    collect(1, 17, 0, 16, 15, 40, "R9");

    // R10: valid mode write restarts bit count only
    prog_div(40, 0);
    collect(1, 3, 0, 16, 40, 0, "R10");
    mode_wr = 1'b1;
    mode_wdata = C8;
    @(negedge clk);
    mode_wr = 1'b0;
    collect(4, 12, 3, 8, 40, 0, "R10");

    // R3 R4 R7: constrained random periods, fractions and modes
    for (int t = 0; t < 25; t++) begin
      int ii = 5 + int'($urandom_range(75));
      int ff = int'($urandom_range(255));
      int osr = ($urandom_range(1) == 0) ? 8 : 16;
      set_mode(osr == 8 ? C8 : C16);
      prog_div(ii, ff);
      collect(1, 2 * osr + 3, 0, osr, ii, ff, "R7");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule